// File: doc/BRIEF.md
# Strobe-Framed Serial-to-Parallel Converter

This block collects a short serial word from a single data line and presents it as a parallel word. The sender pulses a start strobe for one clock. The data line is then sampled on the next four clocks, one bit per clock. In the clock period after the fourth bit, the assembled word and a valid flag are driven together for exactly one period. A downstream consumer latches the word whenever the flag is high.

Control is a Moore sequencer with six states, each held in its own flip-flop (one-hot):

- `ST_IDLE`: waiting for a strobe.
- Four capture states, `ST_CAP0` to `ST_CAP3`: each one shifts in one bit.
- `ST_DONE`: presents the word.

The transitions are:

- Idle to itself while the strobe is low.
- Idle to `ST_CAP0` on a strobe.
- Each capture state to the next one.
- `ST_CAP3` to `ST_DONE`.
- `ST_DONE` to `ST_CAP0` on a strobe, or back to idle otherwise.
- Synchronous reset from any state to idle.

Because a strobe in the done state leads straight into the next capture, words can be sent back to back with no idle cycle between them. A reset in the middle of a word discards the partial word.

Top module: `s2p_converter`

## Requirements
- R1: When `rst` is high at a rising clock edge, the block enters idle whatever the other inputs are. From the next period on, `par_valid` is 0 and `par_out` is 0.
- R2: In idle with `frame_start` low, the block stays idle and `par_valid` stays 0, whatever `ser_in` does.
- R3: A `frame_start` high in idle (with `rst` low) starts a word. The first data bit is the value of `ser_in` in the clock period right after the strobe period, not the value during the strobe period.
- R4: The four data bits are sampled on four consecutive clock periods. The first bit appears on `par_out[3]` and the fourth on `par_out[0]`.
- R5: `par_valid` is high for exactly one clock period, the one right after the fourth data bit's period, and `par_out` then holds the word. In the following period `par_valid` is 0 unless a new word has completed.
- R6: Whenever `par_valid` is 0, `par_out` is 0.
- R7: A `frame_start` high during the valid period (with `rst` low) starts the next word immediately. Its first bit is sampled in the very next period, with no idle cycle.
- R8: A reset during any capture period drops the partial word. No valid period appears for it, and a later word is assembled correctly from its own four bits only.
- R9: `frame_start` is ignored during the capture periods. The word in progress completes unchanged, and its valid period appears on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-period strobe announcing a word |
| ser_in | input | 1 | Serial data line |
| par_out | output | 4 | Assembled word, first bit in bit 3; zero when not valid |
| par_valid | output | 1 | High for the one period in which `par_out` holds a word |

## Verification
The bench builds the block with its package default of a four-bit word, which gives six state flops. With that setting all sixteen word values and every state and transition can be reached within a few thousand random cycles. The random strobe and reset rates produce the cases that matter:

- chained words from the done state,
- strobes landing inside a word,
- resets at every capture position.

Directed sequences pin down the strobe-period sample exclusion and the single-period valid pulse.

// File: rtl/s2p_pkg.sv
package s2p_pkg;

    // Width of the assembled parallel word.
    localparam int WORD_BITS  = 4;
    // Idle + one capture state per bit + done.
    localparam int NUM_STATES = WORD_BITS + 2;

    // Bit positions of the states in the one-hot state vector.
    typedef enum int unsigned {
        ST_IDLE      = 0,
        ST_CAP_FIRST = 1,
        ST_CAP_LAST  = WORD_BITS,
        ST_DONE      = WORD_BITS + 1
    } state_idx_e;

    typedef logic [NUM_STATES-1:0] state_vec_t;
    typedef logic [WORD_BITS-1:0]  word_t;

    localparam state_vec_t IDLE_ONEHOT = state_vec_t'(1) << ST_IDLE;

endpackage

// File: rtl/s2p_sequencer.sv
module s2p_sequencer
    import s2p_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output state_vec_t state_q,
    output logic       capture_en,
    output logic       done_st
);

    state_vec_t state_d;

    // Next-state logic: one equation per state flop.
    always_comb begin
        state_d = '0;
        if (rst) begin
            state_d[ST_IDLE] = 1'b1;
        end else begin
            // Rest in idle, or fall back to it after a word without a new strobe.
            state_d[ST_IDLE]      = (state_q[ST_IDLE] | state_q[ST_DONE]) & ~start;
            // A strobe in idle or in done enters the first capture state.
            state_d[ST_CAP_FIRST] = (state_q[ST_IDLE] | state_q[ST_DONE]) & start;
            // Capture states advance unconditionally; the last one feeds done.
            for (int k = ST_CAP_FIRST + 1; k <= ST_DONE; k++) begin
                state_d[k] = state_q[k-1];
            end
        end
    end

    // State register; the idle flop is the one set by reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IDLE_ONEHOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore decodes from the state flops.
    always_comb begin
        capture_en = |state_q[ST_CAP_LAST:ST_CAP_FIRST];
        done_st    = state_q[ST_DONE];
    end

endmodule

// File: rtl/s2p_shifter.sv
module s2p_shifter
    import s2p_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  bit_in,
    output word_t word_q
);

    // Shift left, so the earliest bit ends up in the MSB.
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= {word_q[WORD_BITS-2:0], bit_in};
        end
    end

endmodule

// File: rtl/s2p_outstage.sv
module s2p_outstage
    import s2p_pkg::*;
(
    input  logic  done_st,
    input  word_t word_q,
    output word_t par_out,
    output logic  par_valid
);

    // Outputs depend on registered state only; the word is forced to zero when not valid.
    always_comb begin
        par_valid = done_st;
        par_out   = done_st ? word_q : '0;
    end

endmodule

// File: rtl/s2p_converter.sv
module s2p_converter
    import s2p_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 ser_in,
    output logic [WORD_BITS-1:0] par_out,
    output logic                 par_valid
);

    state_vec_t state_q;
    logic       capture_en;
    logic       done_st;
    word_t      word_q;

    s2p_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (frame_start),
        .state_q    (state_q),
        .capture_en (capture_en),
        .done_st    (done_st)
    );

    s2p_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (capture_en),
        .bit_in   (ser_in),
        .word_q   (word_q)
    );

    s2p_outstage u_out (
        .done_st   (done_st),
        .word_q    (word_q),
        .par_out   (par_out),
        .par_valid (par_valid)
    );

endmodule

// File: rtl/s2p_converter_chk.sv
module s2p_converter_chk
    import s2p_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 frame_start,
    input logic [WORD_BITS-1:0] par_out,
    input logic                 par_valid,
    input state_vec_t           state_q
);

    // R1
    onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state_q) == 1);

    // R1
    reset_to_idle_chk: assert property (@(posedge clk)
        rst |=> (state_q == IDLE_ONEHOT) && !par_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q[ST_IDLE] && !frame_start) |=> state_q[ST_IDLE]);

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        par_valid |=> !par_valid);

    // R5
    last_cap_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        state_q[ST_CAP_LAST] |=> par_valid);

    // R6
    zero_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !par_valid |-> (par_out == '0));

    // R7
    chain_start_chk: assert property (@(posedge clk) disable iff (rst)
        (par_valid && frame_start) |=> state_q[ST_CAP_FIRST]);

    // R9
    cap_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
        state_q[ST_CAP_FIRST] |=> state_q[ST_CAP_FIRST+1]);

endmodule

bind s2p_converter s2p_converter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .par_out     (par_out),
    .par_valid   (par_valid),
    .state_q     (state_q)
);

// File: tb/s2p_converter_tb.sv
module s2p_converter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic       ser_in = 1'b0;
    logic [3:0] par_out;
    logic       par_valid;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model: phase 0 idle, 1..4 capturing, 5 done.
    int         m_ph   = 0;
    logic [3:0] m_word = 4'h0;

    always #5 clk = ~clk;

    s2p_converter u_dut (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .ser_in      (ser_in),
        .par_out     (par_out),
        .par_valid   (par_valid)
    );

    function automatic int next_phase(int ph, logic r, logic s);
        if (r) return 0;
        if (ph == 0 || ph == 5) return s ? 1 : 0;
        return ph + 1;
    endfunction

    function automatic logic [3:0] exp_out(int ph, logic [3:0] w);
        return (ph == 5) ? w : 4'h0;
    endfunction

    // Apply one period of inputs, advance the model at the edge, check after it.
    task automatic cyc(input logic r, input logic s, input logic d, input string tag);
        rst = r; frame_start = s; ser_in = d;
        @(posedge clk);
        if (!r && m_ph >= 1 && m_ph <= 4) m_word = {m_word[2:0], d};
        m_ph = next_phase(m_ph, r, s);
        @(negedge clk);
        n_vec++;
        if (par_valid !== (m_ph == 5) || par_out !== exp_out(m_ph, m_word)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b out=%h expected valid=%0b out=%h",
                     tag, par_valid, par_out, (m_ph == 5), exp_out(m_ph, m_word));
        end
    endtask

    // Strobe then four bits (first bit = w[3]); the strobe-period data is the inverse of w[3].
    task automatic send_word(input logic [3:0] w, input string tag);
        cyc(1'b0, 1'b1, ~w[3], tag);
        for (int i = 3; i >= 0; i--) cyc(1'b0, 1'b0, w[i], tag);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        @(negedge clk);
        cyc(1'b1, 1'b1, 1'b1, "R1");
        cyc(1'b1, 1'b0, 1'b0, "R1");
        // R2: idle, data toggling, no strobe
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, i[0], "R2");
        // R3/R4: MSB-first assembly; strobe-period data excluded
        send_word(4'b1011, "R3");
        cyc(1'b0, 1'b0, 1'b1, "R5");   // valid drops after one period
        send_word(4'b0110, "R4");
        // R7: strobe during valid chains straight into the next word
        cyc(1'b0, 1'b1, 1'b0, "R7");
        cyc(1'b0, 1'b0, 1'b1, "R7");
        cyc(1'b0, 1'b0, 1'b1, "R7");
        cyc(1'b0, 1'b0, 1'b0, "R7");
        cyc(1'b0, 1'b0, 1'b0, "R7");   // done: 1100
        cyc(1'b0, 1'b0, 1'b0, "R5");
        // R8: reset after two bits, then a full word
        cyc(1'b0, 1'b1, 1'b0, "R8");
        cyc(1'b0, 1'b0, 1'b1, "R8");
        cyc(1'b0, 1'b0, 1'b1, "R8");
        cyc(1'b1, 1'b0, 1'b1, "R8");
        cyc(1'b0, 1'b0, 1'b1, "R8");
        cyc(1'b0, 1'b0, 1'b0, "R8");
        send_word(4'b0001, "R8");
        // R9: strobes inside a word have no effect
        cyc(1'b0, 1'b1, 1'b0, "R9");
        cyc(1'b0, 1'b1, 1'b1, "R9");
        cyc(1'b0, 1'b1, 1'b0, "R9");
        cyc(1'b0, 1'b1, 1'b0, "R9");
        cyc(1'b0, 1'b1, 1'b1, "R9");   // done: 1001
        cyc(1'b0, 1'b0, 1'b0, "R6");
        // Random mix: strobes, resets, gaps
        for (int i = 0; i < 4000; i++) begin
            logic r, s, d;
            r = ($urandom % 50) == 0;
            s = ($urandom % 3) == 0;
            d = $urandom % 2;
            cyc(r, s, d, (next_phase(m_ph, r, s) == 5) ? "R5" : "R6");
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule